// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for short bursts of up to four beats. An enabled clock edge with the advance input low either captures a new full address together with the access type (when the combined select is high) or ends the current burst (when select is low). An enabled edge with the advance input high steps the two least significant address bits to the next beat. Select and the write request are ignored while stepping, so the access type captured at the start applies to every beat of the burst.

Beats follow one of two orders, chosen by a static order input: a linear order that counts the low bits upward modulo four, or an interleaved order that combines the start value with the beat index by exclusive-or. The upper address bits do not change during a burst. Once the fourth beat has passed, the same four-value cycle repeats. An edge with clock enable low is a stall and changes nothing.

The control is a two-state machine. SEQ_IDLE means no burst is open. SEQ_BURST means a burst is open. The transitions are:
- load: SEQ_IDLE to SEQ_BURST, or SEQ_BURST to SEQ_BURST as a restart.
- advance: SEQ_BURST to SEQ_BURST, stepping the beat.
- deselect: any state to SEQ_IDLE.
- idle-advance: SEQ_IDLE to SEQ_IDLE, with no effect.
- stall: no change in either state.

Top module: `burst_seq`

## Requirements
- R1: After reset, addr_out is 0, acc_wr is 0 and burst_act is 0.
- R2: On an enabled edge (clk_en=1) with adv=0 and sel=1, addr_out becomes addr_in, acc_wr becomes wr and burst_act becomes 1, all after that edge.
- R3: With order_ilv=0 (linear order), each enabled advance (adv=1) while burst_act=1 sets addr_out[1:0] to the previous value plus one modulo 4. A start of 2'b10 gives 10, 11, 00, 01.
- R4: With order_ilv=1 (interleaved order), beat k of a burst (k=0 at load) has addr_out[1:0] equal to start[1:0] XOR k. A start of 2'b01 gives 01, 00, 11, 10.
- R5: An enabled advance steps the burst whatever the values of sel and wr, and leaves acc_wr and burst_act unchanged.
- R6: During an advance, addr_out[ADDR_W-1:2] does not change.
- R7: Advancing past the fourth beat continues the same cycle, so the fifth beat equals the start address.
- R8: An edge with clk_en=0 leaves addr_out, acc_wr and burst_act unchanged, whatever the other inputs are.
- R9: An enabled edge with adv=0 and sel=0 clears burst_act. Later advances leave burst_act at 0 and addr_out unchanged until a load (R2) opens a new burst.
- R10: A load while a burst is open restarts the beat sequence at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock qualifier; 0 stalls the edge |
| adv | input | 1 | 1 = step the burst, 0 = load or deselect |
| sel | input | 1 | Combined chip select, active high; used only when adv=0 |
| wr | input | 1 | Write request captured at load (1 = write) |
| order_ilv | input | 1 | Static beat order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current beat address |
| acc_wr | output | 1 | Access type held for the burst |
| burst_act | output | 1 | A burst is open |

## Verification
A corrupted beat counter appears on addr_out[1:0] at the first enabled edge after the fault. The wrong value then repeats once per four beats, so the bench compares every beat of each burst. It also runs through the wrap, because a counter that saturates instead of wrapping looks correct for the first four beats. A wrong state-machine state appears as burst_act differing one edge after a load or deselect. A held-access-type fault appears on acc_wr when wr toggles during an advance. A stall that leaks through appears as any output changing after an edge with clk_en low.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_t;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import burst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic adv,
    input  logic sel,
    output logic do_load,
    output logic do_step,
    output logic burst_act
);

    seq_state_t state_q;
    seq_state_t state_d;

    // next state
    always_comb begin
        state_d = state_q;
        if (clk_en) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (!adv && sel)
                        state_d = SEQ_BURST;   // load
                end
                SEQ_BURST: begin
                    if (!adv && !sel)
                        state_d = SEQ_IDLE;    // deselect
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        do_load   = 1'b0;
        do_step   = 1'b0;
        burst_act = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                do_load = clk_en && !adv && sel;
            end
            SEQ_BURST: begin
                burst_act = 1'b1;
                do_load   = clk_en && !adv && sel;
                do_step   = clk_en && adv;
            end
            default: ;
        endcase
    end

    // R9
    idle_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && !burst_act) |=> !burst_act);

    // R9
    deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && !sel) |=> !burst_act);

endmodule

// File: rtl/beat_ctr.sv
module beat_ctr #(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_step,
    output logic [LOW_W-1:0] beat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            beat <= '0;
        else if (do_load)
            beat <= '0;
        else if (do_step)
            beat <= beat + 1'b1;
    end

    // R10
    load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_load |=> (beat == '0));

endmodule

// File: rtl/start_hold.sv
module start_hold #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr,
    output logic [ADDR_W-1:0] start,
    output logic              wr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start <= '0;
            wr_q  <= 1'b0;
        end else if (do_load) begin
            start <= addr_in;
            wr_q  <= wr;
        end
    end

endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              adv,
    input  logic              sel,
    input  logic              wr,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              acc_wr,
    output logic              burst_act
);

    localparam int HI_W = ADDR_W - LOW_W;

    logic              do_load;
    logic              do_step;
    logic [LOW_W-1:0]  beat;
    logic [ADDR_W-1:0] start;
    logic [LOW_W-1:0]  low_lin;
    logic [LOW_W-1:0]  low_ilv;

    seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv       (adv),
        .sel       (sel),
        .do_load   (do_load),
        .do_step   (do_step),
        .burst_act (burst_act)
    );

    beat_ctr #(.LOW_W(LOW_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (do_load),
        .do_step (do_step),
        .beat    (beat)
    );

    start_hold #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_load (do_load),
        .addr_in (addr_in),
        .wr      (wr),
        .start   (start),
        .wr_q    (acc_wr)
    );

    assign low_lin  = start[LOW_W-1:0] + beat;
    assign low_ilv  = start[LOW_W-1:0] ^ beat;
    assign addr_out = {start[ADDR_W-1:LOW_W], (order_ilv ? low_ilv : low_lin)};

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv && sel) |=> (addr_out == $past(addr_in)) && (acc_wr == $past(wr)) && burst_act);

    // R5
    advance_keeps_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && burst_act) |=> $stable(acc_wr) && burst_act);

    // R6
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv) |=> (addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W])));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv && burst_act && !order_ilv) ##1 !order_ilv
        |-> (addr_out[LOW_W-1:0] == LOW_W'($past(addr_out[LOW_W-1:0]) + 1'b1)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && $stable(order_ilv)) ##1 $stable(order_ilv)
        |-> $stable(addr_out) && $stable(acc_wr) && $stable(burst_act));

endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;

    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en = 1'b0;
    logic              adv = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic              order_ilv = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              acc_wr;
    logic              burst_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_seq #(.ADDR_W(ADDR_W), .LOW_W(2)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .adv       (adv),
        .sel       (sel),
        .wr        (wr),
        .order_ilv (order_ilv),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .acc_wr    (acc_wr),
        .burst_act (burst_act)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at the falling edge, sample 1 ns after the rising edge
    task automatic edge_drive(input logic en, input logic a, input logic s,
                              input logic w, input logic [ADDR_W-1:0] ad);
        @(negedge clk);
        clk_en  = en;
        adv     = a;
        sel     = s;
        wr      = w;
        addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        check("R1 addr", 32'(addr_out), 32'h0);
        check("R1 acc_wr", 32'(acc_wr), 32'h0);
        check("R1 burst_act", 32'(burst_act), 32'h0);
    endtask

    task automatic t_linear();
        logic [ADDR_W-1:0] st;
        st = 20'h1234E;   // low bits 10
        order_ilv = 1'b0;
        edge_drive(1, 0, 1, 1, st);
        check("R2 addr", 32'(addr_out), 32'(st));
        check("R2 acc_wr", 32'(acc_wr), 32'h1);
        check("R2 burst_act", 32'(burst_act), 32'h1);
        for (int k = 1; k <= 4; k++) begin
            edge_drive(1, 1, 1, 1, 20'h0);
            check("R3 linear low", 32'(addr_out[1:0]), 32'((st[1:0] + k) % 4));
            check("R6 upper", 32'(addr_out[ADDR_W-1:2]), 32'(st[ADDR_W-1:2]));
        end
        check("R7 linear wrap", 32'(addr_out), 32'(st));
    endtask

    task automatic t_interleave();
        logic [ADDR_W-1:0] st;
        logic [1:0] kk;
        st = 20'hABC01;   // low bits 01
        order_ilv = 1'b1;
        edge_drive(1, 0, 1, 0, st);
        check("R2 ilv load", 32'(addr_out), 32'(st));
        check("R2 ilv acc_wr", 32'(acc_wr), 32'h0);
        for (int k = 1; k <= 4; k++) begin
            edge_drive(1, 1, 1, 0, 20'h0);
            kk = 2'(k);
            check("R4 ilv low", 32'(addr_out[1:0]), 32'(st[1:0] ^ kk));
            check("R6 ilv upper", 32'(addr_out[ADDR_W-1:2]), 32'(st[ADDR_W-1:2]));
        end
        check("R7 ilv wrap", 32'(addr_out), 32'(st));
        order_ilv = 1'b0;
    endtask

    task automatic t_ignore();
        edge_drive(1, 0, 1, 1, 20'h55550);
        edge_drive(1, 1, 0, 0, 20'hFFFFF);
        check("R5 step ignores sel", 32'(addr_out), 32'h55551);
        check("R5 acc_wr held", 32'(acc_wr), 32'h1);
        check("R5 burst_act held", 32'(burst_act), 32'h1);
    endtask

    task automatic t_stall();
        edge_drive(1, 0, 1, 1, 20'h0F0F2);
        edge_drive(0, 0, 1, 0, 20'h11111);
        check("R8 stall load addr", 32'(addr_out), 32'h0F0F2);
        check("R8 stall load type", 32'(acc_wr), 32'h1);
        edge_drive(0, 1, 1, 0, 20'h0);
        check("R8 stall advance", 32'(addr_out), 32'h0F0F2);
        edge_drive(0, 0, 0, 0, 20'h0);
        check("R8 stall deselect", 32'(burst_act), 32'h1);
        edge_drive(1, 1, 1, 0, 20'h0);
        check("R8 after stall", 32'(addr_out), 32'h0F0F3);
    endtask

    task automatic t_deselect();
        logic [ADDR_W-1:0] held;
        edge_drive(1, 0, 1, 0, 20'h22221);
        edge_drive(1, 0, 0, 0, 20'h99999);
        check("R9 deselect", 32'(burst_act), 32'h0);
        held = addr_out;
        edge_drive(1, 1, 1, 1, 20'h0);
        check("R9 idle advance act", 32'(burst_act), 32'h0);
        check("R9 idle advance addr", 32'(addr_out), 32'(held));
        edge_drive(1, 0, 1, 1, 20'h33333);
        check("R9 reload act", 32'(burst_act), 32'h1);
        check("R9 reload addr", 32'(addr_out), 32'h33333);
    endtask

    task automatic t_reload();
        edge_drive(1, 0, 1, 0, 20'h44440);
        edge_drive(1, 1, 1, 0, 20'h0);
        edge_drive(1, 1, 1, 0, 20'h0);
        check("R10 mid burst", 32'(addr_out), 32'h44442);
        edge_drive(1, 0, 1, 1, 20'h77773);
        check("R10 restart addr", 32'(addr_out), 32'h77773);
        check("R10 restart type", 32'(acc_wr), 32'h1);
        edge_drive(1, 1, 1, 0, 20'h0);
        check("R10 restart step", 32'(addr_out), 32'h77770);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_linear();
        t_interleave();
        t_ignore();
        t_stall();
        t_deselect();
        t_reload();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule